// File: doc/BRIEF.md
# UART Channel Mode Data Router

This block sits between a UART's host data port, its receive and transmit FIFOs and the serial line logic. It decides where every byte goes. A byte written by the host and a byte that arrives from the line can each go to one FIFO, to both FIFOs, or nowhere. The choice depends on a two-bit channel mode (normal, echo, local loopback, remote loopback) and on the enable and disable bits of the receive and transmit paths. The block drives one push strobe with data to each FIFO. It raises an overrun event when a byte meets a full FIFO.

The block also tells the line side how many bytes it can take right now. This figure starts at the larger of the two FIFO depths. It is then limited by the free space of each FIFO that the current mode feeds from the line. A small control register holds the enable and disable bits. Two of its bits are not stored and only act as one-cycle clear pulses to the FIFOs. The FIFO storage and the bit-level serializer are outside this block.

Top module: `uart_chan_router`

## Requirements
- R1: The mode input uses these encodings: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. A line byte is routed to the receive FIFO in modes 0 and 1. It is routed to the transmit FIFO in modes 1 and 3. In mode 2 it is dropped.
- R2: A host byte is routed to the transmit FIFO in mode 0 and to the receive FIFO in mode 2. In modes 1 and 3 it is dropped.
- R3: In echo mode, one line byte is pushed to both FIFOs in the same cycle, with the same data.
- R4: readyCount equals max(RX_DEPTH, TX_DEPTH). In modes 0 and 1 it is limited to RX_DEPTH minus rxCount. In modes 1 and 3 it is limited to TX_DEPTH minus txCount. It follows its inputs combinationally.
- R5: The receive path is active only when control bit 2 (enable) is 1 and bit 3 (disable) is 0. The transmit path uses bits 4 and 5 in the same way. A byte routed to an inactive path is dropped and raises no overrun.
- R6: A byte routed to an active receive path while rxCount equals RX_DEPTH is not pushed, and overrunEvt is raised.
- R7: A byte routed to an active transmit path while txCount equals TX_DEPTH is not pushed, and overrunEvt is raised.
- R8: A control write with bit 0 set gives a one-cycle rxClear pulse. A control write with bit 1 set gives a one-cycle txClear pulse. Neither bit is kept in the register.
- R9: After reset, the control register holds the path bits of the value 0x128: both disables set and both enables clear. rxPathOn and txPathOn are therefore low, and all strobes are low.
- R10: Push strobes, push data, overrunEvt and clear pulses are registered. They appear on the clock edge that samples the requesting inputs. A control write takes effect on routing from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 6 | Control bits: 0 rx clear, 1 tx clear, 2 rx enable, 3 rx disable, 4 tx enable, 5 tx disable |
| chanMode | input | 2 | Channel mode field (bits 9:8 of the mode register) |
| hostWrEn | input | 1 | Host write to the data register |
| hostWrData | input | DATA_W | Host byte |
| lineRxEn | input | 1 | Byte received from the line |
| lineRxData | input | DATA_W | Line byte |
| rxCount | input | $clog2(RX_DEPTH+1) | Receive FIFO fill level |
| txCount | input | $clog2(TX_DEPTH+1) | Transmit FIFO fill level |
| rxPush | output | 1 | Push into receive FIFO |
| rxPushData | output | DATA_W | Receive FIFO push data |
| txPush | output | 1 | Push into transmit FIFO |
| txPushData | output | DATA_W | Transmit FIFO push data |
| rxClear | output | 1 | Receive FIFO clear pulse |
| txClear | output | 1 | Transmit FIFO clear pulse |
| overrunEvt | output | 1 | A routed byte met a full FIFO |
| rxPathOn | output | 1 | Receive path active |
| txPathOn | output | 1 | Transmit path active |
| readyCount | output | $clog2(max depth+1) | Number of line bytes that can be accepted now |

## Verification
In echo mode a single line byte feeds two destinations at once. The bench uses this to make a push and an overrun happen in the same cycle: the receive FIFO is reported full while the transmit FIFO has room. The expected result is a transmit push of the line byte, no receive push, and overrunEvt high, all on the same edge. The bench also puts a control write in the same cycle as a line byte. It checks that the byte is judged against the old path bits and that the new bits act only from the next cycle.

// File: rtl/uart_router_pkg.sv
package uart_router_pkg;

  localparam int CTRL_W = 6;
  localparam int BIT_RX_CLR = 0;
  localparam int BIT_TX_CLR = 1;
  localparam int BIT_RX_EN  = 2;
  localparam int BIT_RX_DIS = 3;
  localparam int BIT_TX_EN  = 4;
  localparam int BIT_TX_DIS = 5;

  // Path bits of the full register reset value 0x128 (bits 5:2 -> 4'b1010)
  localparam logic [3:0] PATH_RESET = 4'b1010;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_ECHO   = 2'd1,
    MODE_LOCAL  = 2'd2,
    MODE_REMOTE = 2'd3
  } chan_mode_e;

  typedef struct packed {
    logic rxPush;
    logic rxFromHost;
    logic txPush;
    logic txFromHost;
    logic overrun;
    logic rxClear;
    logic txClear;
  } route_strobe_t;

endpackage

// File: rtl/uart_router_ctrl.sv
module uart_router_ctrl
  import uart_router_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  localparam int RXC_W = $clog2(RX_DEPTH + 1),
  localparam int TXC_W = $clog2(TX_DEPTH + 1),
  localparam int MAXD  = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
  localparam int RDY_W = $clog2(MAXD + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWrEn,
  input  logic [CTRL_W-1:0]   ctrlWrData,
  input  logic [1:0]          chanMode,
  input  logic                hostWrEn,
  input  logic                lineRxEn,
  input  logic [RXC_W-1:0]    rxCount,
  input  logic [TXC_W-1:0]    txCount,
  output route_strobe_t       strobe,
  output logic                rxPathOn,
  output logic                txPathOn,
  output logic [RDY_W-1:0]    readyCount
);

  // stored path bits: [0] rx en, [1] rx dis, [2] tx en, [3] tx dis
  logic [3:0] pathQ;
  chan_mode_e mode;
  logic lineToRx, lineToTx, hostToRx, hostToTx;
  logic rxReq, txReq, rxFull, txFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pathQ <= PATH_RESET;
    end else if (ctrlWrEn) begin
      pathQ <= ctrlWrData[BIT_TX_DIS:BIT_RX_EN];
    end
  end

  assign rxPathOn = pathQ[0] & ~pathQ[1];
  assign txPathOn = pathQ[2] & ~pathQ[3];

  assign mode     = chan_mode_e'(chanMode);
  assign lineToRx = (mode == MODE_NORMAL) || (mode == MODE_ECHO);
  assign lineToTx = (mode == MODE_ECHO)   || (mode == MODE_REMOTE);
  assign hostToTx = (mode == MODE_NORMAL);
  assign hostToRx = (mode == MODE_LOCAL);

  assign rxReq  = (lineRxEn & lineToRx) | (hostWrEn & hostToRx);
  assign txReq  = (lineRxEn & lineToTx) | (hostWrEn & hostToTx);
  assign rxFull = rxCount >= RXC_W'(RX_DEPTH);
  assign txFull = txCount >= TXC_W'(TX_DEPTH);

  always_comb begin
    strobe            = '0;
    strobe.rxFromHost = hostToRx;
    strobe.txFromHost = hostToTx;
    strobe.rxPush     = rxReq & rxPathOn & ~rxFull;
    strobe.txPush     = txReq & txPathOn & ~txFull;
    strobe.overrun    = (rxReq & rxPathOn & rxFull) | (txReq & txPathOn & txFull);
    strobe.rxClear    = ctrlWrEn & ctrlWrData[BIT_RX_CLR];
    strobe.txClear    = ctrlWrEn & ctrlWrData[BIT_TX_CLR];
  end

  logic [RDY_W-1:0] rxFree, txFree, cap;
  always_comb begin
    rxFree = RDY_W'(RX_DEPTH) - RDY_W'(rxCount);
    txFree = RDY_W'(TX_DEPTH) - RDY_W'(txCount);
    cap    = RDY_W'(MAXD);
    if (lineToRx && (rxFree < cap)) cap = rxFree;
    if (lineToTx && (txFree < cap)) cap = txFree;
  end
  assign readyCount = cap;

endmodule

// File: rtl/uart_router_dp.sv
module uart_router_dp
  import uart_router_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  route_strobe_t     strobe,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] lineRxData,
  output logic              rxPush,
  output logic [DATA_W-1:0] rxPushData,
  output logic              txPush,
  output logic [DATA_W-1:0] txPushData,
  output logic              rxClear,
  output logic              txClear,
  output logic              overrunEvt
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPush     <= 1'b0;
      txPush     <= 1'b0;
      rxClear    <= 1'b0;
      txClear    <= 1'b0;
      overrunEvt <= 1'b0;
      rxPushData <= '0;
      txPushData <= '0;
    end else begin
      rxPush     <= strobe.rxPush;
      txPush     <= strobe.txPush;
      rxClear    <= strobe.rxClear;
      txClear    <= strobe.txClear;
      overrunEvt <= strobe.overrun;
      if (strobe.rxPush) rxPushData <= strobe.rxFromHost ? hostWrData : lineRxData;
      if (strobe.txPush) txPushData <= strobe.txFromHost ? hostWrData : lineRxData;
    end
  end

endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
  import uart_router_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  localparam int RXC_W = $clog2(RX_DEPTH + 1),
  localparam int TXC_W = $clog2(TX_DEPTH + 1),
  localparam int MAXD  = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
  localparam int RDY_W = $clog2(MAXD + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [5:0]        ctrlWrData,
  input  logic [1:0]        chanMode,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              lineRxEn,
  input  logic [DATA_W-1:0] lineRxData,
  input  logic [RXC_W-1:0]  rxCount,
  input  logic [TXC_W-1:0]  txCount,
  output logic              rxPush,
  output logic [DATA_W-1:0] rxPushData,
  output logic              txPush,
  output logic [DATA_W-1:0] txPushData,
  output logic              rxClear,
  output logic              txClear,
  output logic              overrunEvt,
  output logic              rxPathOn,
  output logic              txPathOn,
  output logic [RDY_W-1:0]  readyCount
);

  route_strobe_t strobe;

  uart_router_ctrl #(
    .RX_DEPTH(RX_DEPTH),
    .TX_DEPTH(TX_DEPTH)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .chanMode(chanMode), .hostWrEn(hostWrEn), .lineRxEn(lineRxEn),
    .rxCount(rxCount), .txCount(txCount),
    .strobe(strobe), .rxPathOn(rxPathOn), .txPathOn(txPathOn),
    .readyCount(readyCount)
  );

  uart_router_dp #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostWrData(hostWrData), .lineRxData(lineRxData),
    .rxPush(rxPush), .rxPushData(rxPushData),
    .txPush(txPush), .txPushData(txPushData),
    .rxClear(rxClear), .txClear(txClear), .overrunEvt(overrunEvt)
  );

endmodule

// File: rtl/uart_router_chk.sv
module uart_router_chk #(
  parameter int DATA_W   = 8,
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  localparam int RXC_W = $clog2(RX_DEPTH + 1),
  localparam int TXC_W = $clog2(TX_DEPTH + 1),
  localparam int MAXD  = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
  localparam int RDY_W = $clog2(MAXD + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWrEn,
  input logic [5:0]        ctrlWrData,
  input logic [1:0]        chanMode,
  input logic              hostWrEn,
  input logic [DATA_W-1:0] hostWrData,
  input logic              lineRxEn,
  input logic [DATA_W-1:0] lineRxData,
  input logic [RXC_W-1:0]  rxCount,
  input logic [TXC_W-1:0]  txCount,
  input logic              rxPush,
  input logic [DATA_W-1:0] rxPushData,
  input logic              txPush,
  input logic [DATA_W-1:0] txPushData,
  input logic              rxClear,
  input logic              txClear,
  input logic              overrunEvt,
  input logic              rxPathOn,
  input logic              txPathOn,
  input logic [RDY_W-1:0]  readyCount
);

  // R5
  rx_path_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> $past(rxPathOn));
  // R5
  tx_path_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    txPush |-> $past(txPathOn));
  // R6
  rx_full_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> ($past(rxCount) < RXC_W'(RX_DEPTH)));
  // R7
  tx_full_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    txPush |-> ($past(txCount) < TXC_W'(TX_DEPTH)));
  // R3
  echo_dual_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanMode == 2'd1 && lineRxEn && rxPathOn && txPathOn &&
     rxCount < RXC_W'(RX_DEPTH) && txCount < TXC_W'(TX_DEPTH))
    |=> (rxPush && txPush && rxPushData == txPushData));
  // R2
  host_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanMode == 2'd3 && hostWrEn && !lineRxEn) |=> (!rxPush && !txPush));
  // R8
  rx_clear_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && ctrlWrData[0]) |=> rxClear);
  // R10
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrunEvt |-> $past(lineRxEn || hostWrEn));
  // R4
  ready_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanMode[1] == 1'b0 && rxCount <= RXC_W'(RX_DEPTH))
    |-> (readyCount <= RDY_W'(RX_DEPTH) - RDY_W'(rxCount)));

endmodule

bind uart_chan_router uart_router_chk #(
  .DATA_W(DATA_W), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)
) chk_i (.*);

// File: tb/uart_chan_router_tb.sv
`timescale 1ns/1ps
module uart_chan_router_tb_top;

  localparam int RXD = 16;
  localparam int TXD = 32;
  localparam int RXC_W = $clog2(RXD + 1);
  localparam int TXC_W = $clog2(TXD + 1);
  localparam int RDY_W = $clog2(TXD + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 1'b0;
  logic [5:0] ctrlWrData = '0;
  logic [1:0] chanMode = '0;
  logic hostWrEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic lineRxEn = 1'b0;
  logic [7:0] lineRxData = '0;
  logic [RXC_W-1:0] rxCount = '0;
  logic [TXC_W-1:0] txCount = '0;
  logic rxPush, txPush, rxClear, txClear, overrunEvt, rxPathOn, txPathOn;
  logic [7:0] rxPushData, txPushData;
  logic [RDY_W-1:0] readyCount;

  always #2 clk = ~clk;

  uart_chan_router #(.DATA_W(8), .RX_DEPTH(RXD), .TX_DEPTH(TXD)) dut_i (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .chanMode(chanMode), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .lineRxEn(lineRxEn), .lineRxData(lineRxData),
    .rxCount(rxCount), .txCount(txCount),
    .rxPush(rxPush), .rxPushData(rxPushData),
    .txPush(txPush), .txPushData(txPushData),
    .rxClear(rxClear), .txClear(txClear), .overrunEvt(overrunEvt),
    .rxPathOn(rxPathOn), .txPathOn(txPathOn), .readyCount(readyCount)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [5:0] ctrlModel;

  task automatic check(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit cWe, logic [5:0] cD, int md,
                      bit hEn, logic [7:0] hD, bit lEn, logic [7:0] lD,
                      int rc, int tc);
    int cap;
    bit rxOn, txOn, rxReq, txReq, eRx, eTx, eOvr;
    logic [7:0] rxByte, txByte;
    ctrlWrEn = cWe; ctrlWrData = cD; chanMode = md[1:0];
    hostWrEn = hEn; hostWrData = hD; lineRxEn = lEn; lineRxData = lD;
    rxCount = RXC_W'(rc); txCount = TXC_W'(tc);
    #1;
    cap = (RXD > TXD) ? RXD : TXD;
    if (md <= 1 && RXD - rc < cap) cap = RXD - rc;
    if ((md == 1 || md == 3) && TXD - tc < cap) cap = TXD - tc;
    check(tag, "readyCount", int'(readyCount), cap);
    rxOn  = ctrlModel[2] && !ctrlModel[3];
    txOn  = ctrlModel[4] && !ctrlModel[5];
    rxReq = (lEn && md <= 1) || (hEn && md == 2);
    txReq = (lEn && (md == 1 || md == 3)) || (hEn && md == 0);
    rxByte = (md == 2) ? hD : lD;
    txByte = (md == 0) ? hD : lD;
    eRx  = rxReq && rxOn && rc < RXD;
    eTx  = txReq && txOn && tc < TXD;
    eOvr = (rxReq && rxOn && rc >= RXD) || (txReq && txOn && tc >= TXD);
    if (cWe) ctrlModel = cD & 6'h3C;
    @(posedge clk); #1;
    check(tag, "rxPush", int'(rxPush), int'(eRx));
    check(tag, "txPush", int'(txPush), int'(eTx));
    if (eRx) check(tag, "rxPushData", int'(rxPushData), int'(rxByte));
    if (eTx) check(tag, "txPushData", int'(txPushData), int'(txByte));
    check(tag, "overrunEvt", int'(overrunEvt), int'(eOvr));
    check(tag, "rxClear", int'(rxClear), int'(cWe && cD[0]));
    check(tag, "txClear", int'(txClear), int'(cWe && cD[1]));
    check(tag, "rxPathOn", int'(rxPathOn), int'(ctrlModel[2] && !ctrlModel[3]));
    check(tag, "txPathOn", int'(txPathOn), int'(ctrlModel[4] && !ctrlModel[5]));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    ctrlModel = 6'b101000;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check("R9", "rxPathOn", int'(rxPathOn), 0);
    check("R9", "txPathOn", int'(txPathOn), 0);
    check("R9", "rxPush", int'(rxPush), 0);
    check("R9", "overrunEvt", int'(overrunEvt), 0);
    rstN = 1'b1;
    // R9: paths off after reset, line byte dropped without overrun
    step("R9", 0, 6'h00, 0, 0, 8'h00, 1, 8'h11, 0, 0);
    // R10: control write with a line byte, old bits govern this cycle
    step("R10", 1, 6'h14, 0, 0, 8'h00, 1, 8'h12, 0, 0);
    // R1/R2: normal mode, line to rx, host to tx
    step("R1", 0, 6'h00, 0, 1, 8'h3C, 1, 8'h5A, 3, 4);
    // R3: echo, line to both, host dropped
    step("R3", 0, 6'h00, 1, 1, 8'h77, 1, 8'h42, 0, 30);
    // R2: local loopback, host to rx, line dropped
    step("R2", 0, 6'h00, 2, 1, 8'h99, 1, 8'h55, 15, 0);
    // R1: remote loopback, line to tx, host dropped
    step("R1", 0, 6'h00, 3, 1, 8'h66, 1, 8'h24, 16, 31);
    // R4: capacity corners
    step("R4", 0, 6'h00, 3, 0, 8'h00, 0, 8'h00, 0, 32);
    step("R4", 0, 6'h00, 0, 0, 8'h00, 0, 8'h00, 16, 0);
    step("R4", 0, 6'h00, 2, 0, 8'h00, 0, 8'h00, 16, 32);
    // R6: rx full
    step("R6", 0, 6'h00, 0, 0, 8'h00, 1, 8'hA1, 16, 0);
    // R7: tx full
    step("R7", 0, 6'h00, 0, 1, 8'hB2, 0, 8'h00, 0, 32);
    // R3/R6: echo with rx full, tx push and overrun in one cycle
    step("R3", 0, 6'h00, 1, 0, 8'h00, 1, 8'hC3, 16, 5);
    // R5: rx enable and disable both set, disable wins
    step("R5", 1, 6'h1C, 0, 0, 8'h00, 0, 8'h00, 0, 0);
    step("R5", 0, 6'h00, 0, 1, 8'hD4, 1, 8'hE5, 16, 0);
    // R5: tx disabled, full tx gives no overrun, rx still active
    step("R5", 1, 6'h34, 0, 0, 8'h00, 0, 8'h00, 0, 0);
    step("R5", 0, 6'h00, 0, 1, 8'hF6, 1, 8'h07, 2, 32);
    // R8: clear pulses, bits not kept
    step("R8", 1, 6'h17, 0, 0, 8'h00, 0, 8'h00, 0, 0);
    step("R8", 0, 6'h00, 0, 0, 8'h00, 0, 8'h00, 0, 0);
    step("R8", 1, 6'h15, 0, 0, 8'h00, 1, 8'h18, 1, 0);
    step("R8", 0, 6'h00, 1, 0, 8'h00, 1, 8'h29, 1, 1);
    finish_run();
  end

endmodule